// File: doc/BRIEF.md
# Program Interrupt Entry Logic

This block carries out the architectural state change when an instruction retires and raises a program interrupt. The cause is either an explicit trap or an opcode that the decoder could not match. Each cycle the core presents four things: a retire strobe, the address of the retiring instruction, the machine state value it ran under, and the next address that the instruction computed. It also raises flags for trap, illegal opcode and attention. The block owns the next-address register, the two save/restore registers, the updated machine state register and a halted flag.

When an interrupt is taken, the block saves the instruction address and the old machine state. It then forces the next address to the interrupt vector, which replaces whatever the instruction produced, and sets one cause bit in the machine state. An attention opcode stops the core instead of trapping. Once halted, the block ignores every later retire until a synchronous reset. The writeback enable output tells the register file whether the retiring instruction may commit its results.

Top module: `prog_int_entry`

## Requirements
- R1: In the cycle after a synchronous reset, the next address equals RESET_PC (default 0x100). Both save/restore registers and the machine state output are zero, and halted is low.
- R2: A retire with no flag set loads the computed next address and copies the input machine state to the output. The save/restore registers keep their values, and writeback enable is high in that cycle.
- R3: A retire that takes a program interrupt sets the next address to VECTOR (default 0x700), whatever next address the instruction computed.
- R4: On interrupt entry, save/restore register 0 receives the retiring instruction's address.
- R5: On interrupt entry, save/restore register 1 receives the input machine state value unmodified.
- R6: A trap entry outputs the input machine state with LSB-0 bit TRAP_IDX (default 17, that is MSB-0 position 63-17) set. All other bits are unchanged.
- R7: An illegal-opcode entry outputs the input machine state with LSB-0 bit ILL_IDX (default 19) set and other bits unchanged. Writeback enable is low for an illegal opcode and high for a trap.
- R8: When trap and illegal flags arrive together, the illegal cause wins. Only bit ILL_IDX is added, and bit TRAP_IDX keeps its input value.
- R9: An attention opcode sets halted and takes precedence over trap and illegal. The next address, the machine state and the save/restore registers keep their values, and writeback enable is low.
- R10: While halted, retires have no effect. All registered outputs hold, and writeback enable stays low until reset.
- R11: In a cycle without a retire, no registered output changes and writeback enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_valid | input | 1 | An instruction retires this cycle |
| trap_hit | input | 1 | The retiring instruction raised a trap |
| opcode_mismatch | input | 1 | The retiring opcode was not recognised |
| attn_op | input | 1 | The retiring instruction is an attention opcode |
| cia | input | XLEN | Address of the retiring instruction |
| msr_cur | input | XLEN | Machine state the instruction ran under |
| calc_nia | input | XLEN | Next address computed by the instruction |
| nia | output | XLEN | Registered next instruction address |
| save0 | output | XLEN | Save/restore register 0 (saved address) |
| save1 | output | XLEN | Save/restore register 1 (saved machine state) |
| msr_out | output | XLEN | Registered machine state after this retire |
| halted | output | 1 | Core stopped by an attention opcode |
| wb_en | output | 1 | Retiring instruction may commit its results |

## Verification
A wrong event decision shows up one clock after the retire. The symptom is either a next address that is not the vector, or one that fails to follow the computed address. A wrong cause-bit position or a lost priority shows in the machine state output on that same edge. A broken halt is caught by the next retire after the attention opcode, because the registers move when they should hold. Writeback enable is combinational, so an error in it is visible in the same cycle as the retire.

// File: rtl/pie_pkg.sv
package pie_pkg;

  // Outcome of one retire cycle, decided by the arbiter
  typedef enum logic [2:0] {
    EV_IDLE    = 3'd0,
    EV_RETIRE  = 3'd1,
    EV_TRAP    = 3'd2,
    EV_ILLEGAL = 3'd3,
    EV_HALT    = 3'd4
  } pie_event_e;

endpackage

// File: rtl/pie_arbiter.sv
module pie_arbiter
  import pie_pkg::*;
(
  input  logic       halted,
  input  logic       step_valid,
  input  logic       trap_hit,
  input  logic       opcode_mismatch,
  input  logic       attn_op,
  output pie_event_e ev,
  output logic       wb_en
);

  // Priority: halt state blocks all, then attention, illegal, trap
  always_comb begin
    if (!step_valid || halted)  ev = EV_IDLE;
    else if (attn_op)           ev = EV_HALT;
    else if (opcode_mismatch)   ev = EV_ILLEGAL;
    else if (trap_hit)          ev = EV_TRAP;
    else                        ev = EV_RETIRE;
  end

  // Results commit for ordinary retires and for traps, never for illegal
  assign wb_en = (ev == EV_RETIRE) || (ev == EV_TRAP);

endmodule

// File: rtl/pie_regs.sv
module pie_regs
  import pie_pkg::*;
#(
  parameter int unsigned    XLEN     = 64,
  parameter logic [XLEN-1:0] VECTOR  = 64'h700,
  parameter logic [XLEN-1:0] RESET_PC = 64'h100,
  parameter int unsigned    TRAP_IDX = 17,
  parameter int unsigned    ILL_IDX  = 19
) (
  input  logic            clk,
  input  logic            rst,
  input  pie_event_e      ev,
  input  logic [XLEN-1:0] cia,
  input  logic [XLEN-1:0] msr_cur,
  input  logic [XLEN-1:0] calc_nia,
  output logic [XLEN-1:0] nia,
  output logic [XLEN-1:0] save0,
  output logic [XLEN-1:0] save1,
  output logic [XLEN-1:0] msr_out,
  output logic            halted
);

  // Set a single LSB-0 bit in a machine state word
  function automatic logic [XLEN-1:0] with_cause(input logic [XLEN-1:0] v,
                                                 input int unsigned idx);
    logic [XLEN-1:0] m;
    m = '0;
    m[idx] = 1'b1;
    return v | m;
  endfunction

  logic            enter;
  logic [XLEN-1:0] msr_entry;

  assign enter = (ev == EV_TRAP) || (ev == EV_ILLEGAL);
  assign msr_entry = (ev == EV_ILLEGAL) ? with_cause(msr_cur, ILL_IDX)
                                        : with_cause(msr_cur, TRAP_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      nia     <= RESET_PC;
      save0   <= '0;
      save1   <= '0;
      msr_out <= '0;
      halted  <= 1'b0;
    end else begin
      if (enter) begin
        nia     <= VECTOR;
        save0   <= cia;
        save1   <= msr_cur;
        msr_out <= msr_entry;
      end else if (ev == EV_RETIRE) begin
        nia     <= calc_nia;
        msr_out <= msr_cur;
      end
      if (ev == EV_HALT) halted <= 1'b1;
    end
  end

endmodule

// File: rtl/prog_int_entry.sv
module prog_int_entry
  import pie_pkg::*;
#(
  parameter int unsigned     XLEN     = 64,
  parameter logic [XLEN-1:0] VECTOR   = 64'h700,
  parameter logic [XLEN-1:0] RESET_PC = 64'h100,
  parameter int unsigned     TRAP_IDX = 17,
  parameter int unsigned     ILL_IDX  = 19
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step_valid,
  input  logic            trap_hit,
  input  logic            opcode_mismatch,
  input  logic            attn_op,
  input  logic [XLEN-1:0] cia,
  input  logic [XLEN-1:0] msr_cur,
  input  logic [XLEN-1:0] calc_nia,
  output logic [XLEN-1:0] nia,
  output logic [XLEN-1:0] save0,
  output logic [XLEN-1:0] save1,
  output logic [XLEN-1:0] msr_out,
  output logic            halted,
  output logic            wb_en
);

  pie_event_e ev;

  // Named events for the checker
  logic trap_taken;
  logic ill_taken;
  logic take_int;
  logic halt_req;

  assign trap_taken = (ev == EV_TRAP);
  assign ill_taken  = (ev == EV_ILLEGAL);
  assign take_int   = trap_taken || ill_taken;
  assign halt_req   = (ev == EV_HALT);

  pie_arbiter u_arb (
    .halted          (halted),
    .step_valid      (step_valid),
    .trap_hit        (trap_hit),
    .opcode_mismatch (opcode_mismatch),
    .attn_op         (attn_op),
    .ev              (ev),
    .wb_en           (wb_en)
  );

  pie_regs #(
    .XLEN     (XLEN),
    .VECTOR   (VECTOR),
    .RESET_PC (RESET_PC),
    .TRAP_IDX (TRAP_IDX),
    .ILL_IDX  (ILL_IDX)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .ev       (ev),
    .cia      (cia),
    .msr_cur  (msr_cur),
    .calc_nia (calc_nia),
    .nia      (nia),
    .save0    (save0),
    .save1    (save1),
    .msr_out  (msr_out),
    .halted   (halted)
  );

endmodule

// File: rtl/pie_checker.sv
module pie_checker #(
  parameter int unsigned     XLEN     = 64,
  parameter logic [XLEN-1:0] VECTOR   = 64'h700,
  parameter int unsigned     TRAP_IDX = 17,
  parameter int unsigned     ILL_IDX  = 19
) (
  input logic            clk,
  input logic            rst,
  input logic            step_valid,
  input logic            opcode_mismatch,
  input logic            attn_op,
  input logic [XLEN-1:0] cia,
  input logic [XLEN-1:0] msr_cur,
  input logic [XLEN-1:0] nia,
  input logic [XLEN-1:0] save0,
  input logic [XLEN-1:0] save1,
  input logic [XLEN-1:0] msr_out,
  input logic            halted,
  input logic            wb_en,
  input logic            trap_taken,
  input logic            ill_taken,
  input logic            take_int,
  input logic            halt_req
);

  localparam logic [XLEN-1:0] TRAP_BIT = XLEN'(1) << TRAP_IDX;

  a_r3_vector: assert property (@(posedge clk) disable iff (rst)
    take_int |=> nia == VECTOR);

  a_r4_save0: assert property (@(posedge clk) disable iff (rst)
    take_int |=> save0 == $past(cia));

  a_r5_save1: assert property (@(posedge clk) disable iff (rst)
    take_int |=> save1 == $past(msr_cur));

  a_r6_trap_cause: assert property (@(posedge clk) disable iff (rst)
    trap_taken |=> msr_out == ($past(msr_cur) | TRAP_BIT));

  a_r7_illegal_no_wb: assert property (@(posedge clk) disable iff (rst)
    ill_taken |-> !wb_en);

  a_r8_illegal_wins: assert property (@(posedge clk) disable iff (rst)
    (step_valid && !halted && !attn_op && opcode_mismatch) |=> msr_out[ILL_IDX]);

  a_r9_attn_halts: assert property (@(posedge clk) disable iff (rst)
    halt_req |=> halted && $stable(nia) && $stable(save0) && $stable(msr_out));

  a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted && $stable(nia) && $stable(save1) && $stable(msr_out));

  a_r10_no_wb: assert property (@(posedge clk) disable iff (rst)
    halted |-> !wb_en);

  a_r11_idle: assert property (@(posedge clk) disable iff (rst)
    !step_valid |=> $stable(nia) && $stable(save0) && $stable(msr_out));

endmodule

bind prog_int_entry pie_checker #(
  .XLEN     (XLEN),
  .VECTOR   (VECTOR),
  .TRAP_IDX (TRAP_IDX),
  .ILL_IDX  (ILL_IDX)
) u_chk (
  .clk             (clk),
  .rst             (rst),
  .step_valid      (step_valid),
  .opcode_mismatch (opcode_mismatch),
  .attn_op         (attn_op),
  .cia             (cia),
  .msr_cur         (msr_cur),
  .nia             (nia),
  .save0           (save0),
  .save1           (save1),
  .msr_out         (msr_out),
  .halted          (halted),
  .wb_en           (wb_en),
  .trap_taken      (trap_taken),
  .ill_taken       (ill_taken),
  .take_int        (take_int),
  .halt_req        (halt_req)
);

// File: tb/prog_int_entry_test.sv
module prog_int_entry_test;

  localparam logic [63:0] VEC   = 64'h700;
  localparam logic [63:0] START = 64'h100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic step_valid = 1'b0, trap_hit = 1'b0, opcode_mismatch = 1'b0, attn_op = 1'b0;
  logic [63:0] cia = '0, msr_cur = '0, calc_nia = '0;
  logic [63:0] nia, save0, save1, msr_out;
  logic halted, wb_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model
  logic [63:0] m_nia, m_s0, m_s1, m_msr;
  logic        m_halt;

  always #2 clk = ~clk;

  prog_int_entry uut (
    .clk(clk), .rst(rst), .step_valid(step_valid), .trap_hit(trap_hit),
    .opcode_mismatch(opcode_mismatch), .attn_op(attn_op), .cia(cia),
    .msr_cur(msr_cur), .calc_nia(calc_nia), .nia(nia), .save0(save0),
    .save1(save1), .msr_out(msr_out), .halted(halted), .wb_en(wb_en)
  );

  function automatic logic [63:0] bit_at(input int k);
    return 64'd1 << k;
  endfunction

  task automatic cmp(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_regs(input string req);
    cmp(req, "nia", nia, m_nia);
    cmp(req, "save0", save0, m_s0);
    cmp(req, "save1", save1, m_s1);
    cmp(req, "msr_out", msr_out, m_msr);
    cmp(req, "halted", {63'd0, halted}, {63'd0, m_halt});
  endtask

  task automatic do_reset();
    rst = 1'b1; step_valid = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rst = 1'b0;
    m_nia = START; m_s0 = '0; m_s1 = '0; m_msr = '0; m_halt = 1'b0;
    check_regs("R1");
  endtask

  // one cycle: drive at negedge, check wb_en, clock, check registers
  task automatic cycle(input string req, input logic sv, input logic tr,
                       input logic il, input logic at, input logic [63:0] a,
                       input logic [63:0] m, input logic [63:0] n);
    logic exp_wb;
    step_valid = sv; trap_hit = tr; opcode_mismatch = il; attn_op = at;
    cia = a; msr_cur = m; calc_nia = n;
    exp_wb = 1'b0;
    #1;
    if (sv && !m_halt) begin
      if (at) m_halt = 1'b1;                       // R9
      else if (il) begin                           // R7 R8
        m_nia = VEC; m_s0 = a; m_s1 = m; m_msr = m | bit_at(19);
      end else if (tr) begin                       // R3 R4 R5 R6
        m_nia = VEC; m_s0 = a; m_s1 = m; m_msr = m | bit_at(17);
        exp_wb = 1'b1;
      end else begin                               // R2
        m_nia = n; m_msr = m; exp_wb = 1'b1;
      end
    end
    cmp(req, "wb_en", {63'd0, wb_en}, {63'd0, exp_wb});
    @(negedge clk);
    check_regs(req);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    do_reset();                                                       // R1
    cycle("R11", 0, 0, 0, 0, 64'h1234, 64'hAAAA, 64'h5555);            // R11 idle
    cycle("R2", 1, 0, 0, 0, 64'h100, 64'hF0, 64'h104);                // R2 plain retire
    cycle("R3", 1, 1, 0, 0, 64'h104, 64'h8000_0000_0000_0001, 64'hBEEF0); // R3 R4 R5 R6
    cycle("R6", 1, 1, 0, 0, 64'h700, bit_at(17), 64'h704);            // R6 bit already set
    cycle("R7", 1, 0, 1, 0, 64'h800, 64'h3, 64'h804);                 // R7 illegal
    cycle("R8", 1, 1, 1, 0, 64'h900, 64'h0, 64'h904);                 // R8 illegal wins
    cycle("R9", 1, 1, 1, 1, 64'hA00, 64'hFFFF, 64'hA04);              // R9 attention first
    cycle("R10", 1, 0, 0, 0, 64'hB00, 64'h77, 64'hB04);               // R10 ignored
    cycle("R10", 1, 1, 0, 0, 64'hC00, 64'h77, 64'hC04);               // R10 trap ignored
    do_reset();                                                       // R1 clears halt
    for (int ep = 0; ep < 40; ep++) begin
      for (int i = 0; i < 80; i++) begin
        logic sv, tr, il, at;
        sv = ($urandom % 10) < 8;
        tr = ($urandom % 100) < 15;
        il = ($urandom % 100) < 10;
        at = ($urandom % 200) < 1;
        cycle("R2-rand", sv, tr, il, at, {$urandom, $urandom},
              {$urandom, $urandom}, {$urandom, $urandom});
      end
      do_reset();
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule